// File: doc/BRIEF.md
# Chroma 4:2:2 to 4:4:4 Upsampler

This block takes a YCbCr pixel stream in which every pixel carries its own luma but only one chroma sample, alternating Cb and Cr from pixel to pixel. It produces a stream in which every pixel carries luma, Cb and Cr. Pixels are counted in pairs from the start of each active line. The first pixel of a pair carries the pair's Cb and the second carries its Cr. The first pixel of the pair already has both of its chroma samples once its neighbour has arrived. The second pixel is co-sited with no chroma of its own and has to be filled in.

Two fill methods are available. The first repeats the pair's chroma, which is a zero-order hold and the state after reset. The second averages the pair's chroma with that of the following pair, which is first-order interpolation. A bypass control lets 4:4:4 data on two chroma lanes pass through untouched when no conversion is needed. Luma, the data-enable and both syncs travel through the same pipeline, so all outputs stay aligned. The fill mode and the bypass control are captured only while the data-enable is low. A line is therefore always converted with one setting.

Top module: `upc_chroma_upsampler`

## Requirements
- R1: Every output (out_de, out_hs, out_vs, out_y, out_cb, out_cr) reflects the input sampled at clock edge k after clock edge k+3.
- R2: With conversion active, a pixel at even index p in a line (p counted from 0) outputs out_cb = its own in_c0 and out_cr = in_c0 of pixel p+1.
- R3: In repetition mode, a pixel at odd index p outputs out_cb = in_c0 of pixel p-1 and out_cr = its own in_c0, the same chroma as pixel p-1.
- R4: In interpolation mode, a pixel at odd index p with p+2 < line length outputs out_cb = (c0[p-1] + c0[p+1] + 1) >> 1 and out_cr = (c0[p] + c0[p+2] + 1) >> 1. The sums are held without overflow, so 255 and 255 give 255.
- R5: In interpolation mode, the last pixel of a line (odd index, no following pair) falls back to the repetition result of R3.
- R6: The pair phase restarts at each rising edge of in_de. The first pixel of every line is an even pixel carrying Cb, even after a one-cycle gap.
- R7: After reset the fill mode is repetition (mode_lin = 0 selects repetition, 1 selects interpolation).
- R8: mode_lin and bypass are captured only on clock edges where in_de is 0. A change while in_de is 1 has no effect on the line in progress.
- R9: With bypass captured as 1, each active pixel outputs out_cb = in_c0 and out_cr = in_c1.
- R10: While in_de is 0, out_cb and out_cr carry in_c0 and in_c1 unchanged.
- R11: While rst_n is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_lin | input | 1 | Fill method: 0 repetition, 1 interpolation (captured in blanking) |
| bypass | input | 1 | 1 passes chroma lanes unchanged (captured in blanking) |
| in_de | input | 1 | Active-video qualifier, one pixel per clock while high |
| in_hs | input | 1 | Horizontal sync, delayed only |
| in_vs | input | 1 | Vertical sync, delayed only |
| in_y | input | DW | Luma |
| in_c0 | input | DW | Alternating chroma (Cb on even pixels, Cr on odd), or Cb in bypass |
| in_c1 | input | DW | Cr lane used only in bypass and blanking |
| out_de | output | 1 | Delayed qualifier |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_y | output | DW | Delayed luma |
| out_cb | output | DW | Reconstructed Cb |
| out_cr | output | DW | Reconstructed Cr |

## Verification
Every result, including the interpolated chroma, is due three edges after the edge that samples the pixel. It appears at the falling edge four counts after the falling edge at which the pixel was driven. The bench builds each line whole, computes every pixel's expected chroma from the line data, and files it into a slot four cycles ahead of the drive. At each falling edge it compares that slot before driving the next input. The checker applies the same window through a four-deep $past that is enabled only after four edges out of reset.

// File: rtl/upc_pkg.sv
package upc_pkg;
  typedef enum logic {FILL_REPEAT = 1'b0, FILL_LINEAR = 1'b1} fill_mode_e;
  // window of four pixels: previous, centre, next, next-but-one
  localparam int unsigned TAP_COUNT  = 4;
  localparam int unsigned CENTER_TAP = 2;
  localparam int unsigned PIPE_EDGES = CENTER_TAP + 1;
endpackage

// File: rtl/upc_tap_line.sv
module upc_tap_line #(
  parameter int unsigned W    = 8,
  parameter int unsigned TAPS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           d,
  output logic [TAPS-1:0][W-1:0] q
);
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) q[g] <= '0;
        else        q[g] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) q[g] <= '0;
        else        q[g] <= q[g-1];
      end
    end
  end
endmodule

// File: rtl/upc_chroma_fill.sv
module upc_chroma_fill #(
  parameter int unsigned DW = 8
) (
  input  logic          de_cur,
  input  logic          ph_cur,
  input  logic          lin_cur,
  input  logic          byp_cur,
  input  logic [DW-1:0] c0_prev,
  input  logic [DW-1:0] c0_cur,
  input  logic [DW-1:0] c0_nx,
  input  logic [DW-1:0] c0_nx2,
  input  logic [DW-1:0] c1_cur,
  input  logic          de_nx,
  input  logic          ph_nx,
  input  logic          de_nx2,
  output logic [DW-1:0] cb,
  output logic [DW-1:0] cr,
  output logic          fill_lin,
  output logic          fill_edge
);
  // rounded midpoint, one extra bit so the carry is kept
  function automatic logic [DW-1:0] midpoint(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, 1'b1};
    return s[DW:1];
  endfunction

  logic has_right;
  logic odd_conv;

  always_comb begin
    has_right = de_nx & de_nx2 & ~ph_nx;
    odd_conv  = de_cur & ~byp_cur & ph_cur;
    fill_lin  = odd_conv & lin_cur & has_right;
    fill_edge = odd_conv & lin_cur & ~has_right;
    if (!de_cur || byp_cur) begin
      cb = c0_cur;
      cr = c1_cur;
    end else if (!ph_cur) begin
      cb = c0_cur;
      cr = c0_nx;
    end else if (fill_lin) begin
      cb = midpoint(c0_prev, c0_nx);
      cr = midpoint(c0_cur, c0_nx2);
    end else begin
      cb = c0_prev;
      cr = c0_cur;
    end
  end
endmodule

// File: rtl/upc_chroma_upsampler.sv
module upc_chroma_upsampler
  import upc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_lin,
  input  logic          bypass,
  input  logic          in_de,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_c0,
  input  logic [DW-1:0] in_c1,
  output logic          out_de,
  output logic          out_hs,
  output logic          out_vs,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cb,
  output logic [DW-1:0] out_cr
);
  localparam int unsigned F_C1  = 0;
  localparam int unsigned F_C0  = DW;
  localparam int unsigned F_Y   = 2 * DW;
  localparam int unsigned F_VS  = 3 * DW;
  localparam int unsigned F_HS  = F_VS + 1;
  localparam int unsigned F_DE  = F_VS + 2;
  localparam int unsigned F_PH  = F_VS + 3;
  localparam int unsigned F_BYP = F_VS + 4;
  localparam int unsigned F_LIN = F_VS + 5;
  localparam int unsigned TW    = F_LIN + 1;
  localparam int unsigned CT    = CENTER_TAP;

  fill_mode_e mode_q;
  logic       byp_q;
  logic       ph_in;
  logic [TW-1:0] head;
  logic [TAP_COUNT-1:0][TW-1:0] taps;

  // captured settings: only while blanking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= FILL_REPEAT;
      byp_q  <= 1'b0;
    end else if (!in_de) begin
      mode_q <= fill_mode_e'(mode_lin);
      byp_q  <= bypass;
    end
  end

  // pair phase: 0 on the first active pixel, then toggles
  assign ph_in = in_de & taps[0][F_DE] & ~taps[0][F_PH];
  assign head  = {mode_q, byp_q, ph_in, in_de, in_hs, in_vs, in_y, in_c0, in_c1};

  upc_tap_line #(.W(TW), .TAPS(TAP_COUNT)) tap_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (head),
    .q    (taps)
  );

  logic          de_cur, ph_cur, lin_cur, byp_cur, hs_cur, vs_cur;
  logic [DW-1:0] y_cur, c0_prev, c0_cur, c0_nx, c0_nx2, c1_cur;
  logic          de_nx, ph_nx, de_nx2;
  logic          unused_taps;

  assign de_cur  = taps[CT][F_DE];
  assign ph_cur  = taps[CT][F_PH];
  assign lin_cur = taps[CT][F_LIN];
  assign byp_cur = taps[CT][F_BYP];
  assign hs_cur  = taps[CT][F_HS];
  assign vs_cur  = taps[CT][F_VS];
  assign y_cur   = taps[CT][F_Y +: DW];
  assign c0_cur  = taps[CT][F_C0 +: DW];
  assign c1_cur  = taps[CT][F_C1 +: DW];
  assign c0_prev = taps[CT+1][F_C0 +: DW];
  assign c0_nx   = taps[CT-1][F_C0 +: DW];
  assign c0_nx2  = taps[CT-2][F_C0 +: DW];
  assign de_nx   = taps[CT-1][F_DE];
  assign ph_nx   = taps[CT-1][F_PH];
  assign de_nx2  = taps[CT-2][F_DE];
  assign unused_taps = ^taps;

  logic [DW-1:0] cb_nxt, cr_nxt;
  logic          fill_lin, fill_edge;

  upc_chroma_fill #(.DW(DW)) fill_i (
    .de_cur   (de_cur),
    .ph_cur   (ph_cur),
    .lin_cur  (lin_cur),
    .byp_cur  (byp_cur),
    .c0_prev  (c0_prev),
    .c0_cur   (c0_cur),
    .c0_nx    (c0_nx),
    .c0_nx2   (c0_nx2),
    .c1_cur   (c1_cur),
    .de_nx    (de_nx),
    .ph_nx    (ph_nx),
    .de_nx2   (de_nx2),
    .cb       (cb_nxt),
    .cr       (cr_nxt),
    .fill_lin (fill_lin),
    .fill_edge(fill_edge)
  );

  // named output-side events for the checker
  logic o_ph, o_lin, o_edge, o_byp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_de <= 1'b0;
      out_hs <= 1'b0;
      out_vs <= 1'b0;
      out_y  <= '0;
      out_cb <= '0;
      out_cr <= '0;
      o_ph   <= 1'b0;
      o_lin  <= 1'b0;
      o_edge <= 1'b0;
      o_byp  <= 1'b0;
    end else begin
      out_de <= de_cur;
      out_hs <= hs_cur;
      out_vs <= vs_cur;
      out_y  <= y_cur;
      out_cb <= cb_nxt;
      out_cr <= cr_nxt;
      o_ph   <= ph_cur;
      o_lin  <= fill_lin;
      o_edge <= fill_edge;
      o_byp  <= byp_cur;
    end
  end
endmodule

// File: rtl/upc_chroma_upsampler_chk.sv
module upc_chroma_upsampler_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_de,
  input logic          in_hs,
  input logic          in_vs,
  input logic [DW-1:0] in_y,
  input logic [DW-1:0] in_c0,
  input logic [DW-1:0] in_c1,
  input logic          out_de,
  input logic          out_hs,
  input logic          out_vs,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_cb,
  input logic [DW-1:0] out_cr,
  input logic          mode_q,
  input logic          byp_q,
  input logic          o_ph,
  input logic          o_lin,
  input logic          o_edge,
  input logic          o_byp
);
  logic [2:0] warm;
  logic       ready;

  always_ff @(posedge clk) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end
  assign ready = (warm == 3'd4);

  AST_CTRL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (out_de == $past(in_de, 4)) && (out_hs == $past(in_hs, 4)) && (out_vs == $past(in_vs, 4))); // R1
  AST_LUMA_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> out_y == $past(in_y, 4)); // R1
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_de |=> $stable(mode_q) && $stable(byp_q)); // R8
  AST_CHROMA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (o_byp || !out_de)) |-> (out_cb == $past(in_c0, 4)) && (out_cr == $past(in_c1, 4))); // R9
  AST_REPEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_de && o_ph && !o_lin && !o_byp) |-> (out_cb == $past(out_cb)) && (out_cr == $past(out_cr))); // R3
  AST_EDGE_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && o_edge) |-> (out_cb == $past(out_cb)) && (out_cr == $past(out_cr)) && !o_lin); // R5
  AST_LINE_START_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_de && !$past(out_de)) |-> !o_ph); // R6
endmodule

bind upc_chroma_upsampler upc_chroma_upsampler_chk #(.DW(DW)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .in_de (in_de),
  .in_hs (in_hs),
  .in_vs (in_vs),
  .in_y  (in_y),
  .in_c0 (in_c0),
  .in_c1 (in_c1),
  .out_de(out_de),
  .out_hs(out_hs),
  .out_vs(out_vs),
  .out_y (out_y),
  .out_cb(out_cb),
  .out_cr(out_cr),
  .mode_q(mode_q),
  .byp_q (byp_q),
  .o_ph  (o_ph),
  .o_lin (o_lin),
  .o_edge(o_edge),
  .o_byp (o_byp)
);

// File: tb/upc_chroma_upsampler_tb_top.sv
`timescale 1ns/1ps
module upc_chroma_upsampler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_lin = 1'b0, bypass = 1'b0;
  logic       in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [7:0] in_y = '0, in_c0 = '0, in_c1 = '0;
  logic       out_de, out_hs, out_vs;
  logic [7:0] out_y, out_cb, out_cr;

  upc_chroma_upsampler #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_lin(mode_lin), .bypass(bypass),
    .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
    .in_y(in_y), .in_c0(in_c0), .in_c1(in_c1),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
    .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  always #5 clk = ~clk;

  int  cyc = 0;
  int  n_chk = 0, n_bad = 0;
  bit  finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // expectation slots, written four counts ahead of the drive
  bit    s_val [16];
  logic  s_de [16], s_hs [16], s_vs [16];
  logic [7:0] s_y [16], s_cb [16], s_cr [16];
  string s_tag [16];

  logic [7:0] lc0 [64], lc1 [64], ly [64];

  function automatic logic [7:0] half_up(input logic [7:0] a, input logic [7:0] b);
    int t;
    t = (int'(a) + int'(b) + 1) / 2;
    return t[7:0];
  endfunction

  function automatic void ref_pixel(input int p, input int n, input bit lin, input bit byp,
                                    output logic [7:0] cb, output logic [7:0] cr, output string tag);
    if (byp) begin
      cb = lc0[p]; cr = lc1[p]; tag = "R9";
    end else if (p % 2 == 0) begin
      cb = lc0[p]; cr = lc0[p+1]; tag = (p == 0) ? "R6" : "R2";
    end else if (lin && (p + 2 < n)) begin
      cb = half_up(lc0[p-1], lc0[p+1]); cr = half_up(lc0[p], lc0[p+2]); tag = "R4";
    end else begin
      cb = lc0[p-1]; cr = lc0[p]; tag = lin ? "R5" : "R3";
    end
  endfunction

  task automatic compare_now();
    int k;
    k = cyc % 16;
    if (s_val[k]) begin
      n_chk++;
      if (out_de !== s_de[k] || out_hs !== s_hs[k] || out_vs !== s_vs[k] ||
          out_y !== s_y[k] || out_cb !== s_cb[k] || out_cr !== s_cr[k]) begin
        n_bad++;
        $display("FAIL %s cyc=%0d got de%b hs%b vs%b y=%h cb=%h cr=%h exp de%b hs%b vs%b y=%h cb=%h cr=%h",
                 s_tag[k], cyc, out_de, out_hs, out_vs, out_y, out_cb, out_cr,
                 s_de[k], s_hs[k], s_vs[k], s_y[k], s_cb[k], s_cr[k]);
      end
      s_val[k] = 1'b0;
    end
  endtask

  task automatic tick(input logic de, input logic [7:0] y, input logic [7:0] c0, input logic [7:0] c1,
                      input logic ml, input logic bp,
                      input logic [7:0] ecb, input logic [7:0] ecr, input string tag);
    int k;
    logic hs, vs;
    @(negedge clk);
    compare_now();
    hs = 1'($urandom()); vs = 1'($urandom());
    in_de = de; in_hs = hs; in_vs = vs; in_y = y; in_c0 = c0; in_c1 = c1;
    mode_lin = ml; bypass = bp;
    k = (cyc + 4) % 16;
    s_val[k] = 1'b1; s_de[k] = de; s_hs[k] = hs; s_vs[k] = vs; s_y[k] = y;
    s_cb[k] = ecb; s_cr[k] = ecr; s_tag[k] = tag;
  endtask

  task automatic blank(input int cnt, input logic ml, input logic bp);
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom()); b = 8'($urandom());
      tick(1'b0, 8'($urandom()), a, b, ml, bp, a, b, "R1 R10");
    end
  endtask

  // pat: 0 random, 1 all ones, 2 pairs alternating 0 and 1
  task automatic line(input int n, input bit lin, input bit byp, input bit flip, input int pat, input string force_tag);
    for (int p = 0; p < n; p++) begin
      ly[p] = 8'($urandom()); lc1[p] = 8'($urandom());
      case (pat)
        1:       lc0[p] = 8'hFF;
        2:       lc0[p] = ((p / 2) % 2 == 1) ? 8'h01 : 8'h00;
        default: lc0[p] = 8'($urandom());
      endcase
    end
    blank(1, lin, byp);  // settings captured here
    for (int p = 0; p < n; p++) begin
      logic [7:0] ecb, ecr;
      string tg;
      logic ml, bp;
      ref_pixel(p, n, lin, byp, ecb, ecr, tg);
      if (force_tag.len() > 0) tg = force_tag;
      ml = (flip && p >= n / 2) ? ~lin : lin;
      bp = (flip && p >= n / 2) ? ~byp : byp;
      tick(1'b1, ly[p], lc0[p], lc1[p], ml, bp, ecb, ecr, tg);
    end
  endtask

  initial begin
    void'($urandom(32'd2417));
    for (int i = 0; i < 16; i++) s_val[i] = 1'b0;
    // R11: outputs held at zero during reset even with busy inputs
    in_de = 1'b1; in_y = 8'hA5; in_c0 = 8'h5A; in_c1 = 8'h3C; in_hs = 1'b1; in_vs = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if ({out_de, out_hs, out_vs, out_y, out_cb, out_cr} !== '0) begin
      n_bad++;
      $display("FAIL R11 reset outputs got %h exp 0", {out_de, out_hs, out_vs, out_y, out_cb, out_cr});
    end
    in_de = 1'b0; in_hs = 1'b0; in_vs = 1'b0; mode_lin = 1'b0;
    rst_n = 1'b1;
    blank(3, 1'b0, 1'b0);
    // R7: first line after reset uses repetition
    line(8, 1'b0, 1'b0, 1'b0, 0, "R7");
    blank(2, 1'b1, 1'b0);
    line(8, 1'b1, 1'b0, 1'b0, 1, "");   // R4 no overflow at full scale
    line(8, 1'b1, 1'b0, 1'b0, 2, "");   // R4 rounding up, one-cycle gap R6
    line(2, 1'b1, 1'b0, 1'b0, 0, "");   // R5 single pair falls back
    line(6, 1'b1, 1'b0, 1'b0, 0, "");   // R6 restart after one blank cycle
    line(10, 1'b0, 1'b0, 1'b1, 0, "R8"); // mode/bypass flip mid-line ignored
    line(10, 1'b1, 1'b0, 1'b1, 0, "R8");
    line(8, 1'b0, 1'b1, 1'b0, 0, "");   // R9 bypass
    line(8, 1'b1, 1'b1, 1'b1, 0, "R8");
    blank(3, 1'b0, 1'b0);
    for (int r = 0; r < 60; r++) begin
      int n;
      bit lin, byp, fl;
      n = 2 * (1 + int'($urandom_range(0, 15)));
      lin = 1'($urandom()); byp = ($urandom_range(0, 3) == 0); fl = 1'($urandom());
      line(n, lin, byp, fl, 0, fl ? "R8" : "");
      blank(int'($urandom_range(0, 3)), lin, byp);
    end
    blank(6, 1'b0, 1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog got cycle %0d exp completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule